// File: doc/BRIEF.md
# Memory-mapped display host interface

This block is the processor-facing port of an eight-digit 5x7 dot-matrix display controller. A host drives it with active-low chip enable, write strobe and read strobe, an active-low flash select, a 5-bit address and an 8-bit data bus. The bus is split here into an input, an output and an output enable. Each access is steered into one of five storage areas: the per-digit character RAM, the per-digit flash bits, the user-character index register, the user-character dot RAM and the control word. The block holds all five of them.

The strobes come from an asynchronous host and pass through a two-flop synchroniser into the controller clock. Address and data are held in a capture register while the write strobe is low. The write takes effect when the synchronised strobe is seen to rise. Reads are combinational from the live address and return the addressed storage through a tristate enable. An active-low reset puts the display-visible storage into a blank state. Access is then held off for a few clocks after reset is released.

Top module: `disp_host_port`

## Requirements
- R1: With `flash_n` low the flash bits are accessed, whatever `addr[4:3]` holds. With `flash_n` high, `addr[4:3]` selects the area: 2'b00 the user-character index, 2'b01 the user-character RAM, 2'b10 the control word, 2'b11 the character RAM.
- R2: The character RAM holds one 8-bit entry per digit, addressed by `addr[2:0]` (digit 0 leftmost). An entry written with bit 7 = 0 holds a 7-bit ASCII code and reads back unchanged.
- R3: An entry written with bit 7 = 1 holds a user-character index in bits 3..0. Bits 6..4 are stored as zero, so it reads back as {1'b1, 3'b000, index}.
- R4: The flash area holds one bit per digit, addressed by `addr[2:0]` and written from data bit 0. A read returns that bit on bit 0 with bits 7..1 at zero.
- R5: The user-character index register stores data bits 3..0 and reads them back with bits 7..4 at zero. That index, together with `addr[2:0]` as the row, addresses a 5-bit row of dots (bits 4..0, 1 = LED on). The row reads back with bits 7..5 at zero.
- R6: Row 7 of the user-character RAM does not exist. A write to it changes nothing, and a read of it returns 8'h00.
- R7: A write needs `ce_n` and `wr_n` both low. It takes effect on the third clock edge after `wr_n` goes high: one clock later the old value still reads back, and four clocks later the new value does.
- R8: `data_oe` is high exactly while `ce_n` and `rd_n` are low, reset is released and the hold-off is over. While `data_oe` is low, `data_o` is 8'h00.
- R9: Reset sets every character RAM entry to 8'h20 and clears the flash bits and the control word. The user-character index register and the user-character RAM keep their contents.
- R10: A write while `rst_n` is low is discarded. So is a write during the first HOLDOFF (3) clocks after `rst_n` rises, and the bus is not driven in that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ce_n | input | 1 | Active-low chip enable |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| rd_n | input | 1 | Active-low read strobe |
| flash_n | input | 1 | Active-low flash-area select |
| addr | input | 5 | Area select (bits 4..3) and location (bits 2..0) |
| data_i | input | 8 | Write data from the bus |
| data_o | output | 8 | Read data to the bus |
| data_oe | output | 1 | Bus drive enable |

## Verification
The bench targets the decode override. A design that still decoded `addr[4:3]` with flash select low would write the flash bit into the control word, and the control word would read back changed. It writes a character with the tag bit set and 1s in bits 6..4. If those bits were stored, the read returns 8'hF5 instead of 8'h85. It writes row 7 of the user-character RAM, where a design without the row guard would store the dots and return nonzero or overwrite another row. It also pulses reset after the user characters are loaded, and a design that cleared them would return zeros. Writes are issued inside reset and inside the hold-off window, where a missing guard would commit them into the control word. Reads one clock and four clocks after the strobe rises pin the commit latency.

// File: rtl/disp_host_port.sv
module disp_host_port #(
  parameter int DIGITS    = 8,
  parameter int UDC_CHARS = 16,
  parameter int UDC_ROWS  = 7,
  parameter int HOLDOFF   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       flash_n,
  input  logic [4:0] addr,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       data_oe
);

  localparam int IW = $clog2(UDC_CHARS);
  localparam int CW = $clog2(HOLDOFF + 1);
  localparam int UDEPTH = UDC_CHARS * 8;
  localparam logic [2:0] ROW_LIM = 3'(UDC_ROWS);
  localparam logic [1:0] SEL_UIDX = 2'b00;
  localparam logic [1:0] SEL_UROW = 2'b01;
  localparam logic [1:0] SEL_CTRL = 2'b10;
  localparam logic [1:0] SEL_CHAR = 2'b11;

  logic [7:0]        char_q [DIGITS];
  logic [DIGITS-1:0] flash_q;
  logic [7:0]        ctrl_q;
  logic [IW-1:0]     uidx_q;
  logic [4:0]        urow_q [UDEPTH];

  logic [CW-1:0] wait_cnt;
  logic [2:0]    wr_sync;
  logic          h_v, h_fl;
  logic [4:0]    h_a;
  logic [7:0]    h_d;
  logic [7:0]    rd_val;

  wire ready   = (wait_cnt == CW'(HOLDOFF));
  wire wr_rise = wr_sync[1] & ~wr_sync[2];
  wire commit  = wr_rise & h_v;
  wire [1:0] h_sel = h_a[4:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      wr_sync  <= 3'b111;
      h_v      <= 1'b0;
      h_fl     <= 1'b1;
      h_a      <= '0;
      h_d      <= '0;
    end else begin
      if (!ready) wait_cnt <= wait_cnt + 1'b1;
      wr_sync <= {wr_sync[1:0], wr_n};
      if (wr_rise) h_v <= 1'b0;
      if (!ce_n && !wr_n && ready) begin
        h_v  <= 1'b1;
        h_fl <= flash_n;
        h_a  <= addr;
        h_d  <= data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DIGITS; i++) char_q[i] <= 8'h20;
      flash_q <= '0;
      ctrl_q  <= '0;
    end else if (commit) begin
      if (!h_fl)
        flash_q[h_a[2:0]] <= h_d[0];
      else if (h_sel == SEL_CTRL)
        ctrl_q <= h_d;
      else if (h_sel == SEL_CHAR)
        char_q[h_a[2:0]] <= h_d[7] ? {1'b1, {(7-IW){1'b0}}, h_d[IW-1:0]} : h_d;
    end
  end

  always_ff @(posedge clk) begin
    if (commit && h_fl) begin
      if (h_sel == SEL_UIDX)
        uidx_q <= h_d[IW-1:0];
      else if (h_sel == SEL_UROW && h_a[2:0] < ROW_LIM)
        urow_q[{uidx_q, h_a[2:0]}] <= h_d[4:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (!flash_n)
      rd_val = {7'b0, flash_q[addr[2:0]]};
    else begin
      case (addr[4:3])
        SEL_UIDX: rd_val = {{(8-IW){1'b0}}, uidx_q};
        SEL_UROW: rd_val = (addr[2:0] < ROW_LIM) ? {3'b0, urow_q[{uidx_q, addr[2:0]}]} : 8'h00;
        SEL_CTRL: rd_val = ctrl_q;
        default:  rd_val = char_q[addr[2:0]];
      endcase
    end
  end

  assign data_oe = rst_n & ready & ~ce_n & ~rd_n;
  assign data_o  = data_oe ? rd_val : 8'h00;

  // R10
  idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (flash_q == '0 && ctrl_q == 8'h00));

  // R7
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ctrl_q));

  // R3
  tag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && h_fl && h_sel == SEL_CHAR && h_d[7]) |=> (char_q[$past(h_a[2:0])][6:4] == 3'b000));

  // R4
  flash_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !flash_n) |-> (data_o[7:1] == 7'b0));

  // R6
  row7_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && flash_n && addr[4:3] == SEL_UROW && addr[2:0] == 3'd7) |-> (data_o == 8'h00));

endmodule

// File: tb/test_disp_host_port.sv
module test_disp_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int HOLDOFF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, flash_n = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic data_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_host_port #(.HOLDOFF(HOLDOFF)) i_disp_host_port (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .rd_n(rd_n),
    .flash_n(flash_n), .addr(addr), .data_i(data_i),
    .data_o(data_o), .data_oe(data_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic fl, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    flash_n = fl; addr = a; data_i = d; ce_n = 0; wr_n = 0;
    repeat (2) @(negedge clk);
    wr_n = 1; ce_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic rd(input logic fl, input logic [4:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk);
    flash_n = fl; addr = a; ce_n = 0; rd_n = 0;
    #2;
    v = data_o; oe = data_oe;
    ce_n = 1; rd_n = 1; flash_n = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (HOLDOFF + 2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] v; logic oe;
    for (int i = 0; i < 8; i++) begin
      rd(1, {2'b11, 3'(i)}, v, oe);
      chk("R9 char blank", v, 8'h20);
    end
    rd(0, 5'd3, v, oe); chk("R9 flash clear", v, 8'h00);
    rd(1, 5'b10000, v, oe); chk("R9 ctrl clear", v, 8'h00);
  endtask

  task automatic t_oe();
    logic [7:0] v; logic oe;
    @(negedge clk); ce_n = 1; rd_n = 0; #2;
    chk("R8 oe no ce", {7'b0, data_oe}, 8'h00);
    chk("R8 data zero idle", data_o, 8'h00);
    ce_n = 0; rd_n = 1; #1;
    chk("R8 oe no rd", {7'b0, data_oe}, 8'h00);
    ce_n = 1;
    rd(1, 5'b11000, v, oe); chk("R8 oe on read", {7'b0, oe}, 8'h01);
  endtask

  task automatic t_char_ascii();
    logic [7:0] v; logic oe;
    for (int i = 0; i < 8; i++) wr(1, {2'b11, 3'(i)}, 8'h41 + 8'(i));
    for (int i = 0; i < 8; i++) begin
      rd(1, {2'b11, 3'(i)}, v, oe);
      chk("R2 ascii digit", v, 8'h41 + 8'(i));
    end
  endtask

  task automatic t_char_tag();
    logic [7:0] v; logic oe;
    wr(1, 5'b11010, 8'hF5);
    rd(1, 5'b11010, v, oe); chk("R3 tagged index", v, 8'h85);
  endtask

  task automatic t_flash();
    logic [7:0] v; logic oe;
    wr(0, 5'b10101, 8'hFF);
    rd(0, 5'b00101, v, oe); chk("R4 flash bit set", v, 8'h01);
    rd(0, 5'b01101, v, oe); chk("R1 flash ignores a4a3", v, 8'h01);
    rd(0, 5'b00100, v, oe); chk("R4 flash neighbour", v, 8'h00);
    rd(1, 5'b10000, v, oe); chk("R1 ctrl untouched by flash", v, 8'h00);
    rd(1, 5'b11101, v, oe); chk("R1 char untouched by flash", v, 8'h46);
  endtask

  task automatic t_udc();
    logic [7:0] v; logic oe;
    wr(1, 5'b00000, 8'hA7);
    rd(1, 5'b00000, v, oe); chk("R5 index reg", v, 8'h07);
    for (int r = 0; r < 7; r++) wr(1, {2'b01, 3'(r)}, 8'hE0 | 8'(r * 3 + 1));
    for (int r = 0; r < 7; r++) begin
      rd(1, {2'b01, 3'(r)}, v, oe);
      chk("R5 row dots", v, 8'(r * 3 + 1) & 8'h1F);
    end
    wr(1, 5'b00000, 8'h03);
    wr(1, 5'b01000, 8'h11);
    rd(1, 5'b01000, v, oe); chk("R5 other char row", v, 8'h11);
    wr(1, 5'b00000, 8'h07);
    rd(1, 5'b01000, v, oe); chk("R5 char kept", v, 8'h01);
  endtask

  task automatic t_row7();
    logic [7:0] v; logic oe;
    wr(1, 5'b01111, 8'h1F);
    rd(1, 5'b01111, v, oe); chk("R6 row7 reads zero", v, 8'h00);
    rd(1, 5'b01110, v, oe); chk("R6 row6 intact", v, 8'h13);
    rd(1, 5'b01000, v, oe); chk("R6 row0 intact", v, 8'h01);
  endtask

  task automatic t_ctrl();
    logic [7:0] v; logic oe;
    wr(1, 5'b10011, 8'h5B);
    rd(1, 5'b10000, v, oe); chk("R1 ctrl word", v, 8'h5B);
    rd(1, 5'b11000, v, oe); chk("R1 char kept by ctrl", v, 8'h41);
  endtask

  task automatic t_latency();
    logic [7:0] v;
    @(negedge clk);
    flash_n = 1; addr = 5'b10000; data_i = 8'h3C; ce_n = 0; wr_n = 0;
    repeat (2) @(negedge clk);
    wr_n = 1; rd_n = 0;
    @(negedge clk); #2; v = data_o;
    chk("R7 old after 1 clk", v, 8'h5B);
    repeat (3) @(negedge clk); #2; v = data_o;
    chk("R7 new after 4 clk", v, 8'h3C);
    ce_n = 1; rd_n = 1;
  endtask

  task automatic t_reset_retain();
    logic [7:0] v; logic oe;
    do_reset();
    rd(1, 5'b11010, v, oe); chk("R9 char reset", v, 8'h20);
    rd(0, 5'b00101, v, oe); chk("R9 flash reset", v, 8'h00);
    rd(1, 5'b10000, v, oe); chk("R9 ctrl reset", v, 8'h00);
    rd(1, 5'b00000, v, oe); chk("R9 index kept", v, 8'h07);
    rd(1, 5'b01010, v, oe); chk("R9 udc kept", v, 8'h07);
  endtask

  task automatic t_holdoff();
    logic [7:0] v; logic oe;
    @(negedge clk);
    rst_n = 0; flash_n = 1; addr = 5'b10000; data_i = 8'h77; ce_n = 0; wr_n = 0; rd_n = 0;
    @(negedge clk); #1;
    chk("R10 no drive in reset", {7'b0, data_oe}, 8'h00);
    @(negedge clk);
    wr_n = 1; rd_n = 1; ce_n = 1;
    repeat (2) @(negedge clk);
    rst_n = 1; data_i = 8'h66; ce_n = 0; wr_n = 0; rd_n = 0;
    @(negedge clk); #1;
    chk("R10 no drive in holdoff", {7'b0, data_oe}, 8'h00);
    @(negedge clk);
    wr_n = 1; rd_n = 1; ce_n = 1;
    repeat (6) @(negedge clk);
    rd(1, 5'b10000, v, oe); chk("R10 writes discarded", v, 8'h00);
    wr(1, 5'b10000, 8'h12);
    rd(1, 5'b10000, v, oe); chk("R10 write after holdoff", v, 8'h12);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_oe();
    t_char_ascii();
    t_char_tag();
    t_flash();
    t_udc();
    t_row7();
    t_ctrl();
    t_latency();
    t_reset_retain();
    t_holdoff();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule